// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 36-bit virtual page number (bits 47 to 12 of a 48-bit virtual address) into a 40-bit physical frame number. It does this by walking a four-level radix page table that lives in memory. A translation cache hands it a request. The walker then starts at the table whose frame number sits on the root base input and reads one 8-byte entry per level over a simple request/response memory port. Each read depends on the entry returned by the read before it.

At every level the walker does three things:
- selects the 9-bit index for that level;
- forms the entry address as the table base plus eight times the index;
- checks the entry's present bit.

A missing entry stops the walk at once and reports a fault together with the level that failed. A complete walk returns the frame number from the last entry, with permission flags merged across all four levels. Only one walk runs at a time, and the request port stays not-ready until that walk reports its result.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: A request is accepted in a cycle with `req_valid` and `req_ready` both high. From the next cycle `req_ready` stays low, and other requests are ignored, until the cycle in which `res_valid` is high; `req_ready` is high again in that cycle.
- R3: The first read of a walk targets `root_base*4096 + 8*I0`, where I0 is `req_vpn[35:27]` (virtual address bits 47..39).
- R4: The reads for levels 1, 2 and 3 target `B*4096 + 8*Ik`. B is bits 51..12 of the entry just returned. Ik is `req_vpn[26:18]`, `[17:9]` and `[8:0]` respectively (virtual address bits 38..30, 29..21, 20..12).
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change.
- R6: A walk whose four entries all have bit 0 (present) set makes exactly four reads. It then gives a one-cycle `res_valid` with `res_fault`=0, `res_level`=3, and `res_pfn` equal to bits 51..12 of the fourth entry.
- R7: An entry with bit 0 clear at level L (0 is the root) ends the walk with no further reads. The walker then gives `res_valid` with `res_fault`=1 and `res_level`=L.
- R8: On success, `res_write` is the AND of entry bit 1 over all four levels, `res_user` is the AND of entry bit 2, and `res_nx` is the OR of entry bit 63. No other entry bits affect the result.
- R9: At most one memory read is outstanding: `mem_req_valid` is low from the accepted read until its response. `res_valid` is never high in two consecutive cycles.
- R10: On a fault, `res_pfn`, `res_write`, `res_user` and `res_nx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 36 | Virtual page number (VA bits 47..12) |
| root_base | input | 40 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended on a missing entry |
| res_level | output | 2 | Level that faulted, or 3 on success |
| res_pfn | output | 40 | Translated frame number |
| res_write | output | 1 | Writable across all levels |
| res_user | output | 1 | User-accessible across all levels |
| res_nx | output | 1 | No-execute at any level |

## Verification
The hardest case to reach from the ports is a second request that arrives while a walk is in flight and sits idle during memory stalls. It must be neither accepted nor allowed to disturb the index or base used for the rest of the current walk. The bench raises `req_valid` with a different page number in the middle of chosen walks, while it stretches request and response timing at random. It then checks that every later entry address still follows the first request and that `req_ready` stays low. Faults are injected at each of the four levels. Unused entry bits are filled with random data, which shows that only the present, permission and base fields are decoded.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;

  typedef struct packed {
    logic wr;
    logic usr;
    logic nx;
  } perm_t;

endpackage

// File: rtl/pt_walker_idx.sv
module pt_walker_idx #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vpn[(LEVELS-g)*IDX_W-1 -: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level == LVL_W'(k)) idx = slice[k];
    end
  end

endmodule

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
#(
  parameter int ENT_W  = 64,
  parameter int WR_BIT = 1,
  parameter int US_BIT = 2,
  parameter int NX_BIT = 63
) (
  input  perm_t            acc,
  input  logic [ENT_W-1:0] entry,
  output perm_t            merged
);

  always_comb begin
    merged.wr  = acc.wr  & entry[WR_BIT];
    merged.usr = acc.usr & entry[US_BIT];
    merged.nx  = acc.nx  | entry[NX_BIT];
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int OFF_W    = 12,
  parameter int PFN_W    = 40,
  parameter int ENT_W    = 64,
  parameter int ESZ_LOG  = 3,
  parameter int PRES_BIT = 0,
  parameter int WR_BIT   = 1,
  parameter int US_BIT   = 2,
  parameter int NX_BIT   = 63,
  localparam int VPN_W   = LEVELS * IDX_W,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PFN_W-1:0] root_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             res_fault,
  output logic [LVL_W-1:0] res_level,
  output logic [PFN_W-1:0] res_pfn,
  output logic             res_write,
  output logic             res_user,
  output logic             res_nx
);

  walk_state_e      state_q;
  logic [LVL_W-1:0] level_q;
  logic [VPN_W-1:0] vpn_q;
  perm_t            perm_q;
  perm_t            perm_nxt;
  logic [PA_W-1:0]  addr_q;

  logic [LVL_W-1:0] sel_level;
  logic [VPN_W-1:0] sel_vpn;
  logic [PFN_W-1:0] sel_base;
  logic [IDX_W-1:0] sel_idx;
  logic [PA_W-1:0]  sel_addr;
  logic [PFN_W-1:0] ent_base;
  logic             last_lvl;

  assign ent_base = mem_rsp_data[PA_W-1:OFF_W];
  assign last_lvl = (level_q == LVL_W'(LEVELS-1));

  // address source: new request when idle, otherwise the next level
  always_comb begin
    if (state_q == ST_IDLE) begin
      sel_level = '0;
      sel_vpn   = req_vpn;
      sel_base  = root_base;
    end else begin
      sel_level = level_q + LVL_W'(1);
      sel_vpn   = vpn_q;
      sel_base  = ent_base;
    end
  end

  pt_walker_idx #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
    .vpn   (sel_vpn),
    .level (sel_level),
    .idx   (sel_idx)
  );

  assign sel_addr = {sel_base, {OFF_W{1'b0}}} + PA_W'({sel_idx, {ESZ_LOG{1'b0}}});

  pt_walker_perm #(.ENT_W(ENT_W), .WR_BIT(WR_BIT), .US_BIT(US_BIT), .NX_BIT(NX_BIT)) u_perm (
    .acc    (perm_q),
    .entry  (mem_rsp_data),
    .merged (perm_nxt)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      level_q   <= '0;
      vpn_q     <= '0;
      perm_q    <= '0;
      addr_q    <= '0;
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_level <= '0;
      res_pfn   <= '0;
      res_write <= 1'b0;
      res_user  <= 1'b0;
      res_nx    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q   <= req_vpn;
            level_q <= '0;
            perm_q  <= '{wr: 1'b1, usr: 1'b1, nx: 1'b0};
            addr_q  <= sel_addr;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[PRES_BIT]) begin
              res_valid <= 1'b1;
              res_fault <= 1'b1;
              res_level <= level_q;
              res_pfn   <= '0;
              res_write <= 1'b0;
              res_user  <= 1'b0;
              res_nx    <= 1'b0;
              state_q   <= ST_IDLE;
            end else if (last_lvl) begin
              res_valid <= 1'b1;
              res_fault <= 1'b0;
              res_level <= level_q;
              res_pfn   <= ent_base;
              res_write <= perm_nxt.wr;
              res_user  <= perm_nxt.usr;
              res_nx    <= perm_nxt.nx;
              state_q   <= ST_IDLE;
            end else begin
              perm_q  <= perm_nxt;
              level_q <= sel_level;
              addr_q  <= sel_addr;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read request must hold steady until taken (R5)
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // accepted request drops ready on the following cycle (R2)
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // result strobe lasts one cycle (R9)
  p_res_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // no new read between acceptance and response (R9)
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // fault carries no frame or permissions (R10)
  p_fault_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_pfn == '0 && !res_write && !res_user && !res_nx));

  // successful result always comes from the last level (R6)
  p_success_last_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault) |-> (res_level == LVL_W'(LEVELS-1)));

  // ready returns together with the result strobe (R2)
  p_ready_with_result_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> req_ready);

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_vpn = '0;
  logic [39:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_fault;
  logic [1:0]  res_level;
  logic [39:0] res_pfn;
  logic        res_write;
  logic        res_user;
  logic        res_nx;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk, .rst, .req_valid, .req_ready, .req_vpn, .root_base,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data,
    .res_valid, .res_fault, .res_level, .res_pfn,
    .res_write, .res_user, .res_nx
  );

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [51:0] exp_addr(input logic [39:0] base, input logic [35:0] vpn, input int lvl);
    logic [8:0] idx;
    idx = 9'(vpn >> (9 * (3 - lvl)));
    return {base, 12'h000} + {40'h0, idx, 3'b000};
  endfunction

  function automatic logic [63:0] make_entry(input bit p, input bit w, input bit u, input bit nx,
                                             input logic [39:0] nb);
    return {nx, 11'($urandom), nb, 9'($urandom), u, w, p};
  endfunction

  // fault_lvl < 0: no fault; perm_mode 0 random, 1 all granted
  task automatic run_walk(input logic [35:0] vpn, input logic [39:0] root,
                          input int fault_lvl, input int perm_mode, input bit poke);
    logic [39:0] base;
    logic [39:0] nb;
    logic [63:0] ent;
    bit ew, eu, enx, p, w, u, nx, ends;
    base = root; ew = 1; eu = 1; enx = 0;
    req_vpn = vpn; root_base = root; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", req_ready == 1'b0, 64'(req_ready), 64'd0);
    for (int l = 0; l < 4; l++) begin
      if (poke) begin
        req_valid = 1'b1;
        req_vpn = ~vpn;
        root_base = ~root;
      end
      while (!mem_req_valid) @(negedge clk);
      chk(l == 0 ? "R3 root entry address" : "R4 level entry address",
          mem_req_addr == exp_addr(base, vpn, l), 64'(mem_req_addr), 64'(exp_addr(base, vpn, l)));
      if (poke) chk("R2 ignored while busy", req_ready == 1'b0, 64'(req_ready), 64'd0);
      repeat ($urandom % 3) @(negedge clk);
      chk("R5 request held", mem_req_valid && mem_req_addr == exp_addr(base, vpn, l),
          64'(mem_req_addr), 64'(exp_addr(base, vpn, l)));
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      repeat ($urandom % 3) begin
        chk("R9 single outstanding", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
        @(negedge clk);
      end
      p  = (l != fault_lvl);
      w  = (perm_mode == 1) ? 1'b1 : ($urandom % 4 != 0);
      u  = (perm_mode == 1) ? 1'b1 : ($urandom % 4 != 0);
      nx = (perm_mode == 1) ? 1'b0 : ($urandom % 4 == 0);
      nb = {8'($urandom), 32'($urandom)};
      ent = make_entry(p, w, u, nx, nb);
      ends = !p || (l == 3);
      if (ends) req_valid = 1'b0;
      mem_rsp_data = ent; mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!p) begin
        chk("R7 fault strobe", res_valid && res_fault, {62'd0, res_valid, res_fault}, 64'd3);
        chk("R7 fault level", res_level == 2'(l), 64'(res_level), 64'(l));
        chk("R10 fault fields clear", res_pfn == 0 && !res_write && !res_user && !res_nx,
            {res_pfn, res_write, res_user, res_nx}, 64'd0);
        chk("R7 no further read", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
        break;
      end
      ew = ew & w; eu = eu & u; enx = enx | nx;
      base = nb;
      if (l == 3) begin
        chk("R6 success strobe", res_valid && !res_fault && res_level == 2'd3,
            {res_valid, res_fault, res_level}, 64'b1011);
        chk("R6 frame number", res_pfn == nb, 64'(res_pfn), 64'(nb));
        chk("R8 merged permissions", {res_write, res_user, res_nx} == {ew, eu, enx},
            64'({res_write, res_user, res_nx}), 64'({ew, eu, enx}));
      end
    end
    chk("R2 ready with result", req_ready == 1'b1, 64'(req_ready), 64'd1);
    @(negedge clk);
    chk("R9 result one cycle", res_valid == 1'b0, 64'(res_valid), 64'd0);
    chk("R9 idle after result", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    chk("R1 reset no read", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
    chk("R1 reset no result", res_valid == 1'b0, 64'(res_valid), 64'd0);
    // directed corners
    run_walk(36'h0_0000_0000, 40'h00_0000_0001, -1, 1, 0);
    run_walk(36'hF_FFFF_FFFF, 40'hFF_FFFF_FFFF, -1, 1, 0);
    run_walk(36'h1_2345_6789, 40'h12_3456_789A, 0, 0, 0);
    run_walk(36'hA_5A5A_5A5A, 40'h00_0ABC_DEF0, 3, 0, 0);
    run_walk(36'h3_0F0F_0F0F, 40'h55_5555_5555, 1, 0, 1);
    run_walk(36'h8_0402_0100, 40'h0F_0000_0000, -1, 0, 1);
    // random mix
    for (int i = 0; i < 200; i++) begin
      run_walk({4'($urandom), 32'($urandom)}, {8'($urandom), 32'($urandom)},
               ($urandom % 5 == 0) ? int'($urandom % 4) : -1, 0, ($urandom % 4 == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule